// File: doc/BRIEF.md
# Window-Based LCD Raster Timing Generator

This block produces the data-enable, horizontal sync and vertical sync strobes for a parallel LCD panel. A pixel counter and a line counter advance on a per-pixel clock enable. Each strobe is the result of testing the current raster position against a window whose coordinates are computed from mode parameters. The parameters are the two periods, the two active sizes, the two sync widths, the two back porches and two polarity bits.

Mode parameters are written through a small write-only register port into staging registers. They are copied into shadow registers only when the raster wraps from the last pixel of the last line back to the origin, so a frame never mixes two modes. A combinational calculator turns the shadow values into window coordinates with modular wrap. A sync polarity of 0 is produced by exchanging the window's start and end rather than by inverting the output.

Top module: `lcd_window_timing`

## Requirements
- R1: When `pix_en` is 1 the pixel position advances by one. After pixel h_period-1 it returns to 0 and the line advances. After line v_period-1 the line returns to 0. When `pix_en` is 0 both positions hold.
- R2: `de_o` is active for pixels x where h_period-h_active-1 <= x < h_period-h_active-1+h_active, on lines y where v_period-v_active <= y <= v_period-1.
- R3: Let hs_a = (de_start + h_period - hbp - hsw) mod h_period and hs_b = (de_start + h_period - hbp) mod h_period, where de_start = h_period-h_active-1. With horizontal polarity 1, `hsync_o` is active for pixels in the half-open range [hs_a, hs_b) on every line.
- R4: Let vs_a = (v_period - v_active + v_period - vbp - vsw) mod v_period and vs_b = (v_period - v_active + v_period - vbp) mod v_period. With vertical polarity 1, `vsync_o` is active in raster order from position (line vs_a, pixel hs_a) up to, but not including, position (line vs_b, pixel hs_a). It therefore changes state only at pixel hs_a.
- R5: A polarity bit of 0 exchanges the start and end of that sync window: hsync uses [hs_b, hs_a), and vsync runs from (vs_b, hs_a) to (vs_a, hs_a). Polarity bit 0 at address 8 is horizontal and bit 1 is vertical.
- R6: A window whose end lies before its start wraps past the counter boundary. It is active at or after the start, or before the end (vertical ranges of the data-enable window: at or before the end).
- R7: Writes with `cfg_we` go to staging registers at `cfg_addr`: 0 h_period, 1 h_active, 2 hsync width, 3 h back porch, 4 v_period, 5 v_active, 6 vsync width, 7 v back porch, 8 polarity. Other addresses are ignored. Staged values take effect only from the clock on which the raster wraps to pixel 0, line 0.
- R8: The outputs are registered. The value after a clock edge reflects the position and mode held before that edge.
- R9: Reset places the raster at pixel 0, line 0, drives all outputs low and loads the default mode into both the staging and shadow registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Per-pixel clock enable |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_addr | input | AW | Mode register address |
| cfg_wdata | input | W | Mode register write data |
| de_o | output | 1 | Data enable |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |

## Verification
The bench keeps the default coordinate width of 12 bits. It programs small modes of 20x10, 16x8 and 16x8 with wrapping syncs, so every pixel of several complete frames is compared against a model computed with plain modulo arithmetic. These small periods bring within reach both sync windows wrapping across pixel 0 and line 0, and both polarity swaps, alone and mixed. They also bring within reach mode writes landing mid-frame, on an ignored address, and with `pix_en` gaps around the frame wrap.

// File: rtl/lcdw_pkg.sv
package lcdw_pkg;
   typedef enum logic [0:0] {
      WIN_RECT   = 1'b0,
      WIN_RASTER = 1'b1
   } win_kind_e;

   localparam int NUM_FIELDS = 8;
   localparam int POL_ADDR   = 8;

   typedef enum int {
      F_HPER = 0, F_HACT = 1, F_HSW = 2, F_HBP = 3,
      F_VPER = 4, F_VACT = 5, F_VSW = 6, F_VBP = 7
   } field_e;
endpackage

// File: rtl/lcdw_cfg_regs.sv
module lcdw_cfg_regs #(
   parameter int W  = 12,
   parameter int AW = 4,
   parameter int NF = lcdw_pkg::NUM_FIELDS,
   parameter logic [NF*W-1:0] DEFS = '0,
   parameter logic [1:0] DEF_POL = 2'b11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [W-1:0]  wdata,
   input  logic          frame_end,
   output logic [W-1:0]  sh_o [NF],
   output logic [1:0]    pol_o
);
   logic [1:0] pol_stg_q;

   for (genvar gi = 0; gi < NF; gi++) begin : g_field
      logic [W-1:0] stg_q;
      logic [W-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stg_q <= DEFS[gi*W +: W];
            sh_q  <= DEFS[gi*W +: W];
         end else begin
            if (frame_end) sh_q <= stg_q;
            if (we && addr == AW'(gi)) stg_q <= wdata;
         end
      end
      assign sh_o[gi] = sh_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pol_stg_q <= DEF_POL;
         pol_o     <= DEF_POL;
      end else begin
         if (frame_end) pol_o <= pol_stg_q;
         if (we && addr == AW'(lcdw_pkg::POL_ADDR)) pol_stg_q <= wdata[1:0];
      end
   end
endmodule

// File: rtl/lcdw_raster_cnt.sv
module lcdw_raster_cnt #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] h_per,
   input  logic [W-1:0] v_per,
   output logic [W-1:0] px,
   output logic [W-1:0] ln,
   output logic         frame_end
);
   logic line_last, frame_last;

   assign line_last  = (px >= h_per - W'(1));
   assign frame_last = (ln >= v_per - W'(1));
   assign frame_end  = en && line_last && frame_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         px <= '0;
         ln <= '0;
      end else if (en) begin
         if (line_last) begin
            px <= '0;
            ln <= frame_last ? '0 : ln + W'(1);
         end else begin
            px <= px + W'(1);
         end
      end
   end
endmodule

// File: rtl/lcdw_window_calc.sv
module lcdw_window_calc #(
   parameter int W = 12
) (
   input  logic [W-1:0] hper, hact, hsw, hbp,
   input  logic [W-1:0] vper, vact, vsw, vbp,
   input  logic [1:0]   pol,
   output logic [W-1:0] de_h0, de_h1, de_v0, de_v1,
   output logic [W-1:0] hs_h0, hs_h1, hs_v0, hs_v1,
   output logic [W-1:0] vs_h0, vs_h1, vs_v0, vs_v1
);
   localparam int EW = W + 2;

   function automatic logic [W-1:0] wrap_once(input logic [EW-1:0] t, input logic [W-1:0] p);
      if (t >= EW'(p)) return W'(t - EW'(p));
      return W'(t);
   endfunction

   logic [W-1:0]  de_hs, de_vs, hs_a, hs_b, vs_a, vs_b;
   logic [EW-1:0] hs_ta, hs_tb, vs_ta, vs_tb;

   always_comb begin
      de_hs = hper - hact - W'(1);
      de_vs = vper - vact;
      hs_tb = EW'(de_hs) + EW'(hper) - EW'(hbp);
      hs_ta = hs_tb - EW'(hsw);
      vs_tb = EW'(de_vs) + EW'(vper) - EW'(vbp);
      vs_ta = vs_tb - EW'(vsw);
      hs_a  = wrap_once(hs_ta, hper);
      hs_b  = wrap_once(hs_tb, hper);
      vs_a  = wrap_once(vs_ta, vper);
      vs_b  = wrap_once(vs_tb, vper);

      de_h0 = de_hs;
      de_h1 = de_hs + hact;
      de_v0 = de_vs;
      de_v1 = de_vs + vact - W'(1);

      hs_h0 = pol[0] ? hs_a : hs_b;
      hs_h1 = pol[0] ? hs_b : hs_a;
      hs_v0 = '0;
      hs_v1 = vper - W'(1);

      vs_h0 = hs_a;
      vs_h1 = hs_a;
      vs_v0 = pol[1] ? vs_a : vs_b;
      vs_v1 = pol[1] ? vs_b : vs_a;
   end
endmodule

// File: rtl/lcdw_window_match.sv
module lcdw_window_match #(
   parameter int W = 12,
   parameter lcdw_pkg::win_kind_e KIND = lcdw_pkg::WIN_RECT
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic [W-1:0] h0,
   input  logic [W-1:0] h1,
   input  logic [W-1:0] v0,
   input  logic [W-1:0] v1,
   output logic         hit
);
   if (KIND == lcdw_pkg::WIN_RECT) begin : g_rect
      logic h_in, v_in;
      always_comb begin
         h_in = (h0 <= h1) ? (x >= h0 && x < h1) : (x >= h0 || x < h1);
         v_in = (v0 <= v1) ? (y >= v0 && y <= v1) : (y >= v0 || y <= v1);
         hit  = h_in && v_in;
      end
   end else begin : g_raster
      logic past_start, before_end, ordered;
      always_comb begin
         past_start = (y > v0) || (y == v0 && x >= h0);
         before_end = (y < v1) || (y == v1 && x < h1);
         ordered    = (v0 < v1) || (v0 == v1 && h0 <= h1);
         hit        = ordered ? (past_start && before_end) : (past_start || before_end);
      end
   end
endmodule

// File: rtl/lcd_window_timing.sv
module lcd_window_timing #(
   parameter int W        = 12,
   parameter int AW       = 4,
   parameter int DEF_HPER = 20,
   parameter int DEF_HACT = 12,
   parameter int DEF_HSW  = 3,
   parameter int DEF_HBP  = 2,
   parameter int DEF_VPER = 10,
   parameter int DEF_VACT = 6,
   parameter int DEF_VSW  = 2,
   parameter int DEF_VBP  = 1,
   parameter logic [1:0] DEF_POL = 2'b11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pix_en,
   input  logic          cfg_we,
   input  logic [AW-1:0] cfg_addr,
   input  logic [W-1:0]  cfg_wdata,
   output logic          de_o,
   output logic          hsync_o,
   output logic          vsync_o
);
   import lcdw_pkg::*;

   localparam int NF = NUM_FIELDS;
   localparam int NWIN = 3;
   localparam logic [NF*W-1:0] DEFS = {
      W'(DEF_VBP), W'(DEF_VSW), W'(DEF_VACT), W'(DEF_VPER),
      W'(DEF_HBP), W'(DEF_HSW), W'(DEF_HACT), W'(DEF_HPER)};

   if (W < 4) begin : g_bad_w
      $error("lcd_window_timing: W must be at least 4");
   end
   if ((1 << AW) <= POL_ADDR) begin : g_bad_aw
      $error("lcd_window_timing: AW too small for the mode register map");
   end
   if (DEF_HACT >= DEF_HPER || DEF_VACT > DEF_VPER || DEF_HPER >= (1 << W)) begin : g_bad_def
      $error("lcd_window_timing: default mode out of range");
   end

   logic [W-1:0] sh [NF];
   logic [1:0]   pol;
   logic [W-1:0] px_q, ln_q;
   logic         frame_end;
   logic [W-1:0] wh0 [NWIN], wh1 [NWIN], wv0 [NWIN], wv1 [NWIN];
   logic [NWIN-1:0] hit, out_q;

   lcdw_cfg_regs #(.W(W), .AW(AW), .NF(NF), .DEFS(DEFS), .DEF_POL(DEF_POL)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .frame_end(frame_end), .sh_o(sh), .pol_o(pol));

   lcdw_raster_cnt #(.W(W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .en(pix_en), .h_per(sh[F_HPER]), .v_per(sh[F_VPER]),
      .px(px_q), .ln(ln_q), .frame_end(frame_end));

   lcdw_window_calc #(.W(W)) u_calc (
      .hper(sh[F_HPER]), .hact(sh[F_HACT]), .hsw(sh[F_HSW]), .hbp(sh[F_HBP]),
      .vper(sh[F_VPER]), .vact(sh[F_VACT]), .vsw(sh[F_VSW]), .vbp(sh[F_VBP]),
      .pol(pol),
      .de_h0(wh0[0]), .de_h1(wh1[0]), .de_v0(wv0[0]), .de_v1(wv1[0]),
      .hs_h0(wh0[1]), .hs_h1(wh1[1]), .hs_v0(wv0[1]), .hs_v1(wv1[1]),
      .vs_h0(wh0[2]), .vs_h1(wh1[2]), .vs_v0(wv0[2]), .vs_v1(wv1[2]));

   for (genvar gw = 0; gw < NWIN; gw++) begin : g_win
      localparam win_kind_e KIND = (gw == 2) ? WIN_RASTER : WIN_RECT;
      lcdw_window_match #(.W(W), .KIND(KIND)) u_match (
         .x(px_q), .y(ln_q), .h0(wh0[gw]), .h1(wh1[gw]), .v0(wv0[gw]), .v1(wv1[gw]),
         .hit(hit[gw]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_q <= '0;
      else        out_q <= hit;
   end

   assign de_o    = out_q[0];
   assign hsync_o = out_q[1];
   assign vsync_o = out_q[2];
endmodule

// File: rtl/lcdw_checker.sv
module lcdw_checker #(
   parameter int W = 12
) (
   input logic         clk,
   input logic         rst_n,
   input logic         pix_en,
   input logic [W-1:0] px,
   input logic [W-1:0] ln,
   input logic [W-1:0] h_per,
   input logic [W-1:0] v_per,
   input logic         frame_end,
   input logic         de_o
);
   p_px_bound_r1: assert property (@(posedge clk) disable iff (!rst_n) px < h_per);
   p_ln_bound_r1: assert property (@(posedge clk) disable iff (!rst_n) ln < v_per);
   p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_en |=> $stable(px) && $stable(ln));
   p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_en && px < h_per - W'(1)) |=> (px == $past(px) + W'(1)) && $stable(ln));
   p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_end |=> $stable(h_per) && $stable(v_per));
   p_de_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
      de_o |-> $past(px) != $past(h_per) - W'(1));
endmodule

bind lcd_window_timing lcdw_checker #(.W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .px(px_q), .ln(ln_q),
   .h_per(sh[0]), .v_per(sh[4]), .frame_end(frame_end), .de_o(de_o));

// File: tb/lcd_window_timing_tb.sv
module lcd_window_timing_tb;
   localparam int W = 12;
   localparam int AW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pix_en = 1'b0;
   logic cfg_we = 1'b0;
   logic [AW-1:0] cfg_addr = '0;
   logic [W-1:0]  cfg_wdata = '0;
   logic de_o, hsync_o, vsync_o;

   int n_tests = 0;
   int n_fail = 0;
   bit done = 0;

   // mode model: 0 hper,1 hact,2 hsw,3 hbp,4 vper,5 vact,6 vsw,7 vbp,8 pol
   int stg [9];
   int sh  [9];
   int bx = 0, by = 0;
   logic [2:0] exp_q;
   bit have_exp = 0;

   always #4 clk = ~clk;

   lcd_window_timing #(.W(W), .AW(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .cfg_we(cfg_we),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .de_o(de_o), .hsync_o(hsync_o), .vsync_o(vsync_o));

   function automatic bit in_half(int x, int a, int b);
      if (a <= b) return (x >= a && x < b);
      return (x >= a || x < b);
   endfunction

   // expected {vsync, hsync, de} at position (x,y) under mode m
   function automatic logic [2:0] model(int x, int y, int m [9]);
      int hp, vp, dh, dv, ha, hb, va, vb, p, s, e;
      logic de, hs, vs;
      hp = m[0]; vp = m[4];
      dh = hp - m[1] - 1;
      dv = vp - m[5];
      ha = (dh + hp - m[3] - m[2]) % hp;
      hb = (dh + hp - m[3]) % hp;
      va = (dv + vp - m[7] - m[6]) % vp;
      vb = (dv + vp - m[7]) % vp;
      de = (x >= dh) && (x < hp - 1) && (y >= dv);
      hs = m[8][0] ? in_half(x, ha, hb) : in_half(x, hb, ha);
      p = y * hp + x;
      s = (m[8][1] ? va : vb) * hp + ha;
      e = (m[8][1] ? vb : va) * hp + ha;
      vs = in_half(p, s, e);
      return {vs, hs, de};
   endfunction

   task automatic check(string req, logic act, logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s at pos(%0d,%0d): actual %0b expected %0b", req, bx, by, act, exp);
      end
   endtask

   task automatic step(bit en, bit we, int addr, int data, string tag);
      @(negedge clk);
      if (have_exp) begin
         check({tag, " R2 R8 de"}, de_o, exp_q[0]);
         check({tag, " R3 R8 hsync"}, hsync_o, exp_q[1]);
         check({tag, " R4 R8 vsync"}, vsync_o, exp_q[2]);
      end
      exp_q = model(bx, by, sh);
      have_exp = 1;
      pix_en = en;
      cfg_we = we;
      cfg_addr = AW'(addr);
      cfg_wdata = W'(data);
      if (en) begin
         if (bx >= sh[0] - 1) begin
            bx = 0;
            if (by >= sh[4] - 1) begin
               by = 0;
               sh = stg;
            end else by++;
         end else bx++;
      end
      if (we && addr <= 8) stg[addr] = (addr == 8) ? (data & 3) : data;
   endtask

   task automatic run(int n, int gap_mod, string tag);
      for (int i = 0; i < n; i++)
         step((gap_mod == 0) || ((i % gap_mod) != 1), 1'b0, 0, 0, tag);
   endtask

   task automatic write_mode(int hp, int ha, int hw, int hb, int vp, int va, int vw, int vb,
                             int pol, string tag);
      step(1, 1, 0, hp, tag); step(1, 1, 1, ha, tag);
      step(1, 1, 2, hw, tag); step(1, 1, 3, hb, tag);
      step(1, 1, 4, vp, tag); step(1, 1, 5, va, tag);
      step(1, 1, 6, vw, tag); step(1, 1, 7, vb, tag);
      step(1, 1, 8, pol, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      stg = '{20, 12, 3, 2, 10, 6, 2, 1, 3};
      sh = stg;
      // R9: outputs low in reset
      repeat (3) begin
         @(negedge clk);
         check("R9 reset de", de_o, 1'b0);
         check("R9 reset hsync", hsync_o, 1'b0);
         check("R9 reset vsync", vsync_o, 1'b0);
      end
      rst_n = 1'b1;
      exp_q = model(0, 0, sh);
      have_exp = 1;
      // R1: default mode, free running then with enable gaps
      run(420, 0, "R1");
      run(650, 3, "R1 gaps");
      // R7 + R5: new mode written mid-frame, both polarities swapped
      run(37, 0, "R7 pre");
      write_mode(16, 10, 2, 1, 8, 5, 1, 1, 0, "R7 R5");
      step(1, 1, 12, 3, "R7 ignored addr");
      run(420, 4, "R7 R5");
      // R6: windows wrapping across pixel 0 and line 0
      write_mode(16, 10, 4, 3, 8, 5, 2, 2, 3, "R6");
      run(400, 0, "R6");
      // R5 + R6: mixed polarity on wrapped windows
      step(1, 1, 8, 2, "R5 R6");
      run(300, 5, "R5 R6 hpol0");
      step(1, 1, 8, 1, "R5 R6");
      run(300, 0, "R5 R6 vpol0");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule